// File: doc/BRIEF.md
# Zero-turnaround pipelined burst SRAM

This block is a synchronous single-port memory. It keeps a shared data bus fully busy when reads and writes are mixed in any order. The address and command are sampled on a rising clock edge. The matching data moves in the following cycle. For a read, the word leaves a register loaded at the sampling edge. For a write, the word is sampled at the next edge. A write therefore lands in the same pipeline slot a read would use, and a change of direction never needs an idle cycle.

A load cycle supplies a full address. Advance cycles then step a 2-bit counter through the other three words of the aligned group of four. The step order is linear or interleaved and is chosen by an input pin. A clock enable freezes the whole block. Three chip enables are checked on load cycles only. A failed check cancels the burst but lets a transfer already in flight finish. Four byte-lane strobes mask writes. An asynchronous output enable can tri-state the bus at any time. The bus is modelled as a read-data output plus a drive-enable output.

Top module: `zbt_sram`

## Requirements
- R1: The data for a read command sampled at edge E is on `rdata`, with `rdata_oe` high, from E until the next edge that samples a new command. After reset `rdata_oe` is low.
- R2: The write data for a write command sampled at edge E is taken from `wdata` at the next enabled edge. Reads and writes may alternate on consecutive cycles with no idle cycle.
- R3: While `cke_n` is high, every other synchronous input is ignored and the outputs, the pending write and the burst state keep their values.
- R4: A load cycle (`ld_n` low) with any chip enable inactive (`ce_n` high, `ce2` low or `ce2_n` high) starts nothing, ends any burst and turns `rdata_oe` off after that edge. A write already waiting for its data still completes.
- R5: `rdata_oe` is low in the cycle after a write command is accepted.
- R6: `ld_n` low loads a new address. `ld_n` high advances the 2-bit counter. After the fourth beat the sequence wraps to the starting word.
- R7: With `ilv` low, beat k of a burst uses low address bits (start + k) mod 4.
- R8: With `ilv` high, beat k uses low address bits start XOR k.
- R9: Byte lane l is `wdata[9l+8:9l]`. It is written only if `bw_n[l]` was low in the command cycle.
- R10: `oe_n` high forces `rdata_oe` low at once, with no clock edge needed.
- R11: An advance cycle with no active burst is a no-operation. It leaves memory unchanged and leaves the bus undriven.
- R12: Every beat of a burst keeps the direction and byte mask captured on its load cycle.
- R13: A read of an address whose write is still waiting for its data returns the newly written lanes merged with the old unwritten lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| cke_n | input | 1 | Active-low clock enable |
| ld_n | input | 1 | Low: load address; high: advance burst |
| ce_n | input | 1 | Active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce2_n | input | 1 | Second active-low chip enable |
| wr_n | input | 1 | Low: write command; high: read command |
| bw_n | input | 4 | Active-low byte-lane write strobes |
| addr | input | 8 | Word address |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | 36 | Write data, one cycle after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Read data |
| rdata_oe | output | 1 | High when the block drives the bus |

## Verification
The whole array is first filled with write bursts. Directed sequences then exercise each ordering corner. Linear and interleaved read bursts start at an unaligned offset and run past four beats, which separates the two orders and shows the wrap. Write-then-read to the same word, with a partial byte mask, tells a forwarded merge apart from stale memory. A deselect between a write command and its data shows that the in-flight write completes while the burst stops. Thousands of constrained random cycles follow. They mix stalls, deselects, advances and flips of the output enable, and catch pipeline-alignment errors that the directed cases do not reach.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   // Low address bits of a burst beat, given the starting bits and beat count
   function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input logic       ilv);
      logic [1:0] sum;
      sum = start + cnt;
      return ilv ? (start ^ cnt) : sum;
   endfunction

endpackage

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [LANES-1:0]          lane_we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_we[l])
            store[waddr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = store[raddr];
   end

endmodule

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              load,
   input  logic              sel,
   input  logic              wr,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ilv,
   output logic              op_v,
   output logic              op_wr,
   output logic [ADDR_W-1:0] op_addr,
   output logic [LANES-1:0]  op_bw_n
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("zbt_burst_ctl: ADDR_W must be at least 3");
   end

   logic              act_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic              wr_q;
   logic [LANES-1:0]  bw_q;
   logic [1:0]        cnt_nxt;

   assign cnt_nxt = cnt_q + 2'd1;

   always_comb begin
      if (load) begin
         op_v    = sel;
         op_wr   = wr;
         op_addr = addr;
         op_bw_n = bw_n;
      end else begin
         op_v    = act_q;
         op_wr   = wr_q;
         op_addr = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_nxt, ilv)};
         op_bw_n = bw_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
         wr_q   <= 1'b0;
         bw_q   <= '1;
      end else if (cke) begin
         if (load) begin
            act_q <= sel;
            if (sel) begin
               base_q <= addr;
               cnt_q  <= '0;
               wr_q   <= wr;
               bw_q   <= bw_n;
            end
         end else if (act_q) begin
            cnt_q <= cnt_nxt;
         end
      end
   end

   // R6
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !load && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

   // R6
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && load && sel) |=> (act_q && cnt_q == 2'd0));

   // R4
   desel_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && load && !sel) |=> !act_q);

   // R11
   idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && !load && !act_q) |=> !act_q);

   // R3
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(act_q) && $stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cke_n,
   input  logic                      ld_n,
   input  logic                      ce_n,
   input  logic                      ce2,
   input  logic                      ce2_n,
   input  logic                      wr_n,
   input  logic [LANES-1:0]          bw_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      ilv,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic                      oe_n,
   output logic [LANES*LANE_W-1:0]   rdata,
   output logic                      rdata_oe
);
   localparam int WIDTH = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("zbt_sram: LANES and LANE_W must be positive");
   end

   logic              cke, load, sel;
   logic              op_v, op_wr;
   logic [ADDR_W-1:0] op_addr;
   logic [LANES-1:0]  op_bw_n;
   logic              pw_v;
   logic [ADDR_W-1:0] pw_addr;
   logic [LANES-1:0]  pw_bw_n;
   logic              drv_q;
   logic [WIDTH-1:0]  rd_q;
   logic [WIDTH-1:0]  arr_word, fwd_word;

   assign cke  = ~cke_n;
   assign load = ~ld_n;
   assign sel  = ~ce_n & ce2 & ~ce2_n;

   zbt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke     (cke),
      .load    (load),
      .sel     (sel),
      .wr      (~wr_n),
      .bw_n    (bw_n),
      .addr    (addr),
      .ilv     (ilv),
      .op_v    (op_v),
      .op_wr   (op_wr),
      .op_addr (op_addr),
      .op_bw_n (op_bw_n)
   );

   zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
      .clk     (clk),
      .we      (cke & pw_v),
      .lane_we (~pw_bw_n),
      .waddr   (pw_addr),
      .wdata   (wdata),
      .raddr   (op_addr),
      .rdata   (arr_word)
   );

   // Merge the data of a write still in its data phase into a read of the same word
   for (genvar l = 0; l < LANES; l++) begin : g_fwd
      assign fwd_word[l*LANE_W +: LANE_W] =
         (pw_v && pw_addr == op_addr && !pw_bw_n[l]) ? wdata[l*LANE_W +: LANE_W]
                                                     : arr_word[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pw_v    <= 1'b0;
         pw_addr <= '0;
         pw_bw_n <= '1;
         drv_q   <= 1'b0;
         rd_q    <= '0;
      end else if (cke) begin
         pw_v    <= op_v & op_wr;
         pw_addr <= op_addr;
         pw_bw_n <= op_bw_n;
         drv_q   <= op_v & ~op_wr;
         if (op_v && !op_wr)
            rd_q <= fwd_word;
      end
   end

   assign rdata    = rd_q;
   assign rdata_oe = drv_q & ~oe_n;

   // R5
   wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && op_v && op_wr) |=> !rdata_oe);

   // R1
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && op_v && !op_wr) |=> drv_q);

   // R4
   desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && load && !sel) |=> !rdata_oe);

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(drv_q) && $stable(rd_q) && $stable(pw_v) && $stable(pw_addr)));

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cke_n, ld_n, ce_n, ce2, ce2_n, wr_n, ilv, oe_n;
   logic [3:0]  bw_n;
   logic [7:0]  addr;
   logic [35:0] wdata;
   logic [35:0] rdata;
   logic        rdata_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench-side model state
   logic [35:0] mem_m [256];
   logic        m_act, m_wr, p_v, e_drv;
   logic [7:0]  m_base, p_addr;
   logic [1:0]  m_cnt;
   logic [3:0]  m_bw, p_bw;
   logic [35:0] e_rd;

   always #2 clk = ~clk;

   zbt_sram dut_i (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .ce_n(ce_n),
      .ce2(ce2), .ce2_n(ce2_n), .wr_n(wr_n), .bw_n(bw_n), .addr(addr),
      .ilv(ilv), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   function automatic logic [1:0] order(input logic [1:0] s, input logic [1:0] k,
                                        input logic i);
      logic [1:0] lin;
      lin = s + k;
      return i ? (s ^ k) : lin;
   endfunction

   function automatic logic [35:0] rand36();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[35:0];
   endfunction

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic check(input string tag);
      logic exp_oe;
      exp_oe = e_drv && !oe_n;
      n_cmp++;
      if (rdata_oe !== exp_oe) begin
         n_bad++;
         $display("FAIL %s: rdata_oe=%b expected %b", tag, rdata_oe, exp_oe);
      end
      if (exp_oe) begin
         n_cmp++;
         if (rdata !== e_rd) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected %h", tag, rdata, e_rd);
         end
      end
   endtask

   // One clock: random write data, model update, edge, check after the edge
   task automatic tick(input string tag);
      logic       op_v, op_w;
      logic [7:0] op_a;
      logic [3:0] op_b;
      wdata = rand36();
      if (!cke_n) begin
         if (p_v)
            for (int l = 0; l < 4; l++)
               if (!p_bw[l]) mem_m[p_addr][l*9 +: 9] = wdata[l*9 +: 9];
         op_v = 0; op_w = 0; op_a = '0; op_b = '1;
         if (!ld_n) begin
            if (!ce_n && ce2 && !ce2_n) begin
               op_v = 1; op_w = !wr_n; op_a = addr; op_b = bw_n;
               m_act = 1; m_base = addr; m_cnt = 0; m_wr = !wr_n; m_bw = bw_n;
            end else begin
               m_act = 0;
            end
         end else if (m_act) begin
            m_cnt = m_cnt + 2'd1;
            op_v = 1; op_w = m_wr; op_b = m_bw;
            op_a = {m_base[7:2], order(m_base[1:0], m_cnt, ilv)};
         end
         p_v = op_v && op_w; p_addr = op_a; p_bw = op_b;
         e_drv = op_v && !op_w;
         if (e_drv) e_rd = mem_m[op_a];
      end
      @(posedge clk); #1;
      check(tag);
   endtask

   task automatic ld(input logic w, input logic [7:0] a, input logic [3:0] b,
                     input string tag);
      cke_n = 0; ld_n = 0; ce_n = 0; ce2 = 1; ce2_n = 0;
      wr_n = !w; addr = a; bw_n = b;
      tick(tag);
   endtask

   task automatic adv(input string tag);
      cke_n = 0; ld_n = 1; addr = $urandom(); wr_n = $urandom(); bw_n = $urandom();
      tick(tag);
   endtask

   task automatic desel(input string tag);
      cke_n = 0; ld_n = 0; ce_n = 0; ce2 = 0; ce2_n = 0; wr_n = $urandom();
      tick(tag);
      ce2 = 1;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         report();
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd4242));
      rst_n = 0; cke_n = 0; ld_n = 1; ce_n = 0; ce2 = 1; ce2_n = 0;
      wr_n = 1; ilv = 0; oe_n = 0; bw_n = '1; addr = '0; wdata = '0;
      m_act = 0; m_wr = 0; m_base = '0; m_cnt = 0; m_bw = '1;
      p_v = 0; p_addr = '0; p_bw = '1; e_drv = 0; e_rd = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset");
      rst_n = 1;
      @(posedge clk); #1;

      // R6 R12 R5: fill the array with linear write bursts, bus stays off
      for (int g = 0; g < 64; g++) begin
         ld(1'b1, 8'(g * 4), 4'b0000, "R5 fill load");
         for (int k = 0; k < 3; k++) adv("R12 fill beat");
      end

      // R7: linear read burst from offset 1, past the wrap
      ilv = 0;
      ld(1'b0, 8'h41, 4'b0000, "R7 linear load");
      for (int k = 0; k < 5; k++) adv("R7 linear beat / R6 wrap");

      // R8: interleaved read burst from offset 2
      ilv = 1;
      ld(1'b0, 8'h96, 4'b0000, "R8 interleaved load");
      for (int k = 0; k < 5; k++) adv("R8 interleaved beat / R6 wrap");
      ilv = 0;

      // R9 R13: partial-lane write then read of the same word right after
      ld(1'b1, 8'h20, 4'b1010, "R9 masked write");
      ld(1'b0, 8'h20, 4'b0000, "R13 read after write");
      ld(1'b0, 8'h20, 4'b0000, "R9 lanes re-read");

      // R2: alternating reads and writes with no idle cycle
      for (int k = 0; k < 8; k++)
         ld(k[0], 8'(8'h30 + k[2:1]), 4'b0000, "R2 alternate");

      // R12: write burst keeps its mask, then read it back
      ld(1'b1, 8'h50, 4'b0110, "R12 masked burst");
      for (int k = 0; k < 3; k++) adv("R12 masked beat");
      ld(1'b0, 8'h50, 4'b0000, "R12 read back");
      for (int k = 0; k < 3; k++) adv("R12 read beat");

      // R3: stall in the middle of a read burst with junk inputs
      ld(1'b0, 8'h84, 4'b0000, "R3 load");
      adv("R3 beat");
      for (int k = 0; k < 3; k++) begin
         cke_n = 1; ld_n = 0; ce2 = 0; wr_n = 0; addr = $urandom(); bw_n = 0;
         tick("R3 stall");
      end
      ce2 = 1;
      adv("R3 resume");
      adv("R3 resume");

      // R4 R11: write then deselect; write completes, advances do nothing
      ld(1'b1, 8'h77, 4'b0000, "R4 write");
      desel("R4 deselect");
      adv("R11 idle advance");
      adv("R11 idle advance");
      ld(1'b0, 8'h77, 4'b0000, "R4 completed write");

      // R10: output enable acts without a clock edge
      ld(1'b0, 8'h10, 4'b0000, "R10 read");
      oe_n = 1; #0.5;
      check("R10 oe_n high");
      oe_n = 0; #0.5;
      check("R10 oe_n low");

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         cke_n = ($urandom_range(0, 9) == 0);
         ld_n  = ($urandom_range(0, 9) < 6);
         ce_n  = ($urandom_range(0, 14) == 0);
         ce2   = ($urandom_range(0, 14) != 0);
         ce2_n = ($urandom_range(0, 14) == 0);
         wr_n  = $urandom();
         bw_n  = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'b0000;
         addr  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom());
         ilv   = $urandom();
         oe_n  = ($urandom_range(0, 9) == 0);
         tick("R2 random");
      end

      done = 1;
      report();
      $finish;
   end
endmodule